// File: doc/BRIEF.md
# Two-bit burst offset sequencer

This block produces the address for each beat of a four-beat memory burst. A load strobe captures a full external address. The two low bits of that address become the burst start offset, and the upper bits are held in a register and passed to the array unchanged. Each cycle with the advance input high consumes one beat. The low two address bits then move to the next offset in the burst order.

A static mode input picks the order. Low selects linear order: the start offset plus the beat count, modulo 4. High selects interleaved order: the start offset XOR the beat count. Both orders are relative to the loaded start, and after the fourth beat they wrap back to it. The beat counter is also an output, so the memory controller can see how many beats have been consumed. A cycle with neither load nor advance holds the current address.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and after its release, with no load yet, `addr_out` is all zeros and `beat_cnt` is 0.
- R2: A clock edge with `load` high makes `addr_out` equal to the sampled `addr_in` and clears `beat_cnt` to 0.
- R3: When `load` and `adv` are high at the same edge, the load wins: `beat_cnt` becomes 0 and `addr_out` equals `addr_in`.
- R4: An edge with `adv` high and `load` low raises `beat_cnt` by one, modulo 4.
- R5: An edge with both `load` and `adv` low leaves `beat_cnt` and `addr_out` unchanged.
- R6: With `mode_il` = 0 (linear), `addr_out[1:0]` equals (start offset + `beat_cnt`) mod 4.
- R7: With `mode_il` = 1 (interleaved), `addr_out[1:0]` equals start offset XOR `beat_cnt`. From start 01 this gives 01,00,11,10, and from start 10 it gives 10,11,00,01.
- R8: `addr_out[ADDR_W-1:2]` changes only at an edge where `load` is high.
- R9: Four advances after a load bring `addr_out[1:0]` back to the start offset, and further advances continue the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_il | input | 1 | Burst order, static: 0 = linear, 1 = interleaved |
| load | input | 1 | Captures `addr_in` and starts a new burst |
| addr_in | input | ADDR_W | External address |
| adv | input | 1 | Consumes one beat |
| addr_out | output | ADDR_W | Address of the current beat to the array |
| beat_cnt | output | 2 | Beats consumed since the last load, modulo 4 |

## Verification
The bench builds the block with `ADDR_W` = 6, so the upper address field has only 16 values. Random loads therefore reach all-zeros and all-ones upper bits often, alongside every start offset in both orders.

Directed bursts run more than four advances from each of the four start offsets, in both modes, to cover the wrap. Loads that coincide with an advance are also driven directly. Long random runs of loads, advances and suspended cycles are checked beat by beat against an offset computed in the bench.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_il,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_cnt
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      cnt_q;
  logic [1:0]      lin_off;
  logic [1:0]      il_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      cnt_q   <= '0;
    end else if (adv) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign lin_off  = start_q + cnt_q;
  assign il_off   = start_q ^ cnt_q;
  assign addr_out = {hi_q, mode_il ? il_off : lin_off};
  assign beat_cnt = cnt_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_il,
  input logic              load,
  input logic [ADDR_W-1:0] addr_in,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat_cnt
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(addr_in)) && (beat_cnt == 2'd0));

  // R4
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> beat_cnt == $past(beat_cnt) + 2'd1);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat_cnt) &&
      ((mode_il != $past(mode_il)) || $stable(addr_out)));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && !mode_il) |=>
      (mode_il || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R7
  inter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && mode_il) |=>
      (!mode_il || (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_cnt ^ $past(beat_cnt))));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_il(mode_il), .load(load), .addr_in(addr_in),
  .adv(adv), .addr_out(addr_out), .beat_cnt(beat_cnt)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_il = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_cnt = '0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .mode_il(mode_il), .load(load), .addr_in(addr_in),
    .adv(adv), .addr_out(addr_out), .beat_cnt(beat_cnt)
  );

  function automatic logic [1:0] exp_off(input logic m, input logic [1:0] s, input logic [1:0] c);
    return m ? (s ^ c) : 2'(s + c);
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_addr[AW-1:2], exp_off(mode_il, m_addr[1:0], m_cnt)};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [AW-1:0] a, input logic av, input string tag);
    @(negedge clk);
    load = ld; addr_in = a; adv = av;
    @(posedge clk);
    if (ld) begin m_addr = a; m_cnt = 2'd0; end
    else if (av) m_cnt = m_cnt + 2'd1;
    #5;
    check({tag, " addr"}, addr_out, exp_addr());
    check({tag, " cnt"}, AW'(beat_cnt), AW'(m_cnt));
  endtask

  initial begin
    #5;
    check("R1 reset addr", addr_out, '0);
    check("R1 reset cnt", AW'(beat_cnt), '0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 after release", addr_out, '0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); mode_il = m[0];
        step(1'b1, AW'({4'hA, s[1:0]}), 1'b0, "R2 load");
        for (int k = 0; k < 6; k++)
          step(1'b0, '0, 1'b1, m[0] ? "R7 interleave" : "R6 linear");
        step(1'b0, '0, 1'b0, "R5 hold");
      end
    end

    mode_il = 1'b1;
    step(1'b1, AW'(6'h05), 1'b0, "R2 load 01");
    step(1'b0, '0, 1'b1, "R7 01 beat1");
    check("R7 01 second offset", AW'(addr_out[1:0]), AW'(2'b00));
    step(1'b0, '0, 1'b1, "R7 01 beat2");
    check("R7 01 third offset", AW'(addr_out[1:0]), AW'(2'b11));
    step(1'b0, '0, 1'b1, "R7 01 beat3");
    step(1'b0, '0, 1'b1, "R9 wrap");
    check("R9 back to start", AW'(addr_out[1:0]), AW'(2'b01));

    step(1'b0, '0, 1'b1, "R4 adv");
    step(1'b1, AW'(6'h3E), 1'b1, "R3 load beats adv");
    check("R3 cnt zero", AW'(beat_cnt), '0);
    step(1'b0, '0, 1'b0, "R5 idle");
    step(1'b0, AW'(6'h01), 1'b0, "R8 addr_in ignored");

    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = ($urandom % 6) == 0;
      if (ld) begin
        @(negedge clk);
        mode_il = $urandom % 2;
      end
      step(ld, AW'($urandom), ($urandom % 3) != 0, "R6/R7/R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule